// File: doc/BRIEF.md
# Selectable Add/Decrement Arithmetic Unit

This block is a combinational n-bit arithmetic unit. One select bit and the incoming carry together pick one of four operations: an addition, an increment, a decrement or a subtraction. It has no clock and no state. A result and a carry-out settle from the operands within one combinational path.

Every bit position has a small conditioning gate. The gate decides what reaches the second input of that bit's full adder: the B bit, a constant 0, a constant 1 or the inverted B bit. The choice depends jointly on the select bit and the incoming carry. The full adders form one ripple chain. The incoming carry always enters the least significant stage. Results wrap modulo 2^n.

Top module: `sel_add_dec_unit`

## Requirements
- R1: With sel_i=0 and cin_i=0 (operation code {sel_i,cin_i}=00), d_o equals (a_i + b_i) mod 2^WIDTH and cout_o is bit WIDTH of the unsigned sum.
- R2: With sel_i=0 and cin_i=1 (code 01), d_o equals (a_i + 1) mod 2^WIDTH.
- R3: With sel_i=1 and cin_i=0 (code 10), d_o equals (a_i - 1) mod 2^WIDTH.
- R4: With sel_i=1 and cin_i=1 (code 11), d_o equals a_i + ~b_i + 1 mod 2^WIDTH, i.e. a_i - b_i in two's complement.
- R5: cout_o is the carry out of the top stage of a_i + Y + cin_i, where Y is the conditioned operand. This gives the following: for increment, cout_o=1 exactly when a_i is all ones; for decrement, cout_o=1 exactly when a_i is nonzero; for subtraction, cout_o=1 exactly when a_i >= b_i as unsigned values.
- R6: In the increment and decrement operations, b_i has no effect on d_o or cout_o.
- R7: WIDTH is a parameter (default 8). The unit behaves as R1 to R5 at other widths, including WIDTH=4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand, conditioned per bit |
| sel_i | input | 1 | Operation select bit |
| cin_i | input | 1 | Incoming carry, also part of the operation code |
| d_o | output | WIDTH | Result, modulo 2^WIDTH |
| cout_o | output | 1 | Carry out of the most significant stage |

## Verification
The checker compares the ports against the arithmetic of each operation whenever the inputs carry known values. It skips any evaluation in which an input is unknown, so it relies on the inputs being fully driven before they are judged. The bench drives every input from its first cycle onward. It changes operands only just after a clock edge and compares results at the opposite edge, so every comparison sees settled combinational values. A four-bit instance is swept over every operand pair and code. The default width receives directed corner values and random operands.

// File: rtl/sau_pkg.sv
package sau_pkg;
  // operation code is {sel, cin}
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_INC = 2'b01,
    OP_DEC = 2'b10,
    OP_SUB = 2'b11
  } sau_op_e;

  function automatic sau_op_e sau_op_of(input logic sel, input logic cin);
    return sau_op_e'({sel, cin});
  endfunction
endpackage

// File: rtl/sau_operand_cond.sv
module sau_operand_cond (
  input  logic sel_i,
  input  logic cin_i,
  input  logic b_i,
  output logic y_o
);
  // 00 -> b, 01 -> 0, 10 -> 1, 11 -> ~b
  assign y_o = (~sel_i & ~cin_i & b_i) | (sel_i & ~cin_i) | (sel_i & cin_i & ~b_i);
endmodule

// File: rtl/sau_full_adder.sv
module sau_full_adder (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic p;
  assign p   = a_i ^ b_i;
  assign s_o = p ^ c_i;
  assign c_o = (a_i & b_i) | (c_i & p);
endmodule

// File: rtl/sau_ripple_chain.sv
module sau_ripple_chain #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH:0] carry;
  assign carry[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    sau_full_adder u_fa (
      .a_i(a_i[i]),
      .b_i(y_i[i]),
      .c_i(carry[i]),
      .s_o(sum_o[i]),
      .c_o(carry[i+1])
    );
  end

  assign cout_o = carry[WIDTH];
endmodule

// File: rtl/sel_add_dec_unit.sv
module sel_add_dec_unit #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sel_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] d_o,
  output logic             cout_o
);
  logic [WIDTH-1:0] y;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cond
    sau_operand_cond u_cond (
      .sel_i(sel_i),
      .cin_i(cin_i),
      .b_i  (b_i[i]),
      .y_o  (y[i])
    );
  end

  sau_ripple_chain #(.WIDTH(WIDTH)) u_chain (
    .a_i   (a_i),
    .y_i   (y),
    .cin_i (cin_i),
    .sum_o (d_o),
    .cout_o(cout_o)
  );
endmodule

// File: rtl/sau_checker.sv
module sau_checker
  import sau_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             sel_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] d_o,
  input logic             cout_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
  logic [WIDTH:0] sum_ab;
  sau_op_e op;

  assign sum_ab = {1'b0, a_i} + {1'b0, b_i};
  assign op     = sau_op_of(sel_i, cin_i);

  always_comb begin
    if (!$isunknown({a_i, b_i, sel_i, cin_i})) begin
      if (op == OP_ADD) begin
        a_r1_add: assert ({cout_o, d_o} == sum_ab);
      end
      if (op == OP_INC) begin
        a_r2_inc: assert (d_o == a_i + ONE);
        a_r5_inc_carry: assert (cout_o == (&a_i));
      end
      if (op == OP_DEC) begin
        a_r3_dec: assert (d_o == a_i - ONE);
        a_r5_dec_carry: assert (cout_o == (|a_i));
      end
      if (op == OP_SUB) begin
        a_r4_sub: assert (d_o == a_i - b_i);
        a_r5_sub_carry: assert (cout_o == (a_i >= b_i));
      end
    end
  end
endmodule

bind sel_add_dec_unit sau_checker #(.WIDTH(WIDTH)) u_chk (
  .a_i   (a_i),
  .b_i   (b_i),
  .sel_i (sel_i),
  .cin_i (cin_i),
  .d_o   (d_o),
  .cout_o(cout_o)
);

// File: tb/sim_sel_add_dec_unit.sv
module sim_sel_add_dec_unit;
  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [7:0] a8 = '0, b8 = '0;
  logic       s8 = 1'b0, c8 = 1'b0;
  logic [7:0] d8;
  logic       co8;
  logic [3:0] a4 = '0, b4 = '0;
  logic       s4 = 1'b0, c4 = 1'b0;
  logic [3:0] d4;
  logic       co4;

  sel_add_dec_unit u0 (
    .a_i(a8), .b_i(b8), .sel_i(s8), .cin_i(c8), .d_o(d8), .cout_o(co8)
  );
  sel_add_dec_unit #(.WIDTH(4)) u1 (
    .a_i(a4), .b_i(b4), .sel_i(s4), .cin_i(c4), .d_o(d4), .cout_o(co4)
  );

  // expected {carry, result} from the operation definitions
  function automatic int ref_val(int w, int a, int b, int s, int c);
    int mask = (1 << w) - 1;
    int d, co;
    case ({s[0], c[0]})
      2'b00: begin d = (a + b) & mask; co = ((a + b) >> w) & 1; end
      2'b01: begin d = (a + 1) & mask; co = (a == mask) ? 1 : 0; end
      2'b10: begin d = (a - 1) & mask; co = (a != 0) ? 1 : 0; end
      default: begin d = (a - b) & mask; co = (a >= b) ? 1 : 0; end
    endcase
    return (co << w) | d;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic drive8(int a, int b, int s, int c);
    @(posedge clk);
    a8 = a[7:0]; b8 = b[7:0]; s8 = s[0]; c8 = c[0];
    @(negedge clk);
  endtask

  task automatic run8(string req, int a, int b, int s, int c);
    drive8(a, b, s, c);
    check(req, {23'd0, co8, d8}, ref_val(8, a, b, s, c));
  endtask

  task automatic t_idle;
    @(negedge clk);
    check("R1 idle zero", {23'd0, co8, d8}, 0);
  endtask

  task automatic t_add;
    run8("R1 add", 8'h12, 8'h34, 0, 0);
    run8("R1 add wrap", 8'hff, 8'h01, 0, 0);
    run8("R1 add max", 8'hff, 8'hff, 0, 0);
    run8("R1 add zero", 8'h5a, 8'h00, 0, 0);
  endtask

  task automatic t_inc;
    run8("R2 inc", 8'h41, 8'h99, 0, 1);
    run8("R2 inc zero", 8'h00, 8'hff, 0, 1);
    run8("R5 inc carry at all ones", 8'hff, 8'h00, 0, 1);
  endtask

  task automatic t_dec;
    run8("R3 dec", 8'h80, 8'h3c, 1, 0);
    run8("R3 dec one", 8'h01, 8'hff, 1, 0);
    run8("R5 dec no carry at zero", 8'h00, 8'h00, 1, 0);
  endtask

  task automatic t_sub;
    run8("R4 sub", 8'h50, 8'h20, 1, 1);
    run8("R4 sub negative", 8'h20, 8'h50, 1, 1);
    run8("R5 sub equal", 8'h77, 8'h77, 1, 1);
    run8("R4 sub from zero", 8'h00, 8'h01, 1, 1);
  endtask

  task automatic t_b_ignored;
    for (int k = 0; k < 16; k++) begin
      run8("R6 inc ignores b", 8'h3e, k * 17, 0, 1);
      run8("R6 dec ignores b", 8'h3e, k * 17, 1, 0);
    end
  endtask

  task automatic t_exhaustive_w4;
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          @(posedge clk);
          a4 = a[3:0]; b4 = b[3:0]; s4 = op[1]; c4 = op[0];
          @(negedge clk);
          check("R7 width4 sweep", {27'd0, co4, d4}, ref_val(4, a, b, op >> 1, op & 1));
        end
  endtask

  task automatic t_random_w8;
    for (int k = 0; k < 400; k++) begin
      int a = int'($urandom_range(255));
      int b = int'($urandom_range(255));
      int op = int'($urandom_range(3));
      run8("R7 width8 random", a, b, op >> 1, op & 1);
    end
  endtask

  initial begin
    t_idle();
    t_add();
    t_inc();
    t_dec();
    t_sub();
    t_b_ignored();
    t_exhaustive_w4();
    t_random_w8();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule